// File: doc/BRIEF.md
# Hardware Volume Button Controller

This block turns two active-low push-buttons, one for louder and one for quieter, into changes of a small attenuation offset and a mute flag. Both button lines pass through a synchronizer. A press counts only once the line has stayed low for a set number of millisecond ticks. A button that stays held keeps stepping at a slower repeat interval. Pressing both buttons together during the qualification window toggles mute. In that case the offset does not move.

The 5-bit offset starts at 27 after reset. The block adds it to a master attenuation value supplied by software and clamps the sum to give the attenuation that drives the DAC. Software can read the offset, overwrite it, and clear the mute flag. A one-cycle `tick_ms` strobe drives every duration, so the timing in milliseconds depends only on how often that strobe arrives.

Top module: `hvol_ctrl`

## Requirements
- R1: After reset `ofs_q` is 27 (0x1B) and `mute_q` is 0.
- R2: A press is released before `QUAL_TICKS` ticks have arrived while it is held. Such a press changes neither the offset nor mute.
- R3: Holding only `vol_up_n` low for `QUAL_TICKS` ticks lowers `ofs_q` by one. More attenuation removed means louder.
- R4: Holding only `vol_dn_n` low for `QUAL_TICKS` ticks raises `ofs_q` by one.
- R5: A single button held past the first step steps again on every further `REPEAT_TICKS` ticks. A hold of k ticks, with k ≥ `QUAL_TICKS`, gives 1 + (k − `QUAL_TICKS`) / `REPEAT_TICKS` steps, using integer division.
- R6: The offset saturates. It stays at 0 under further up-steps and at 31 under further down-steps.
- R7: If both buttons are seen low within one qualification window, `mute_q` toggles once. The offset does not change, and holding the buttons longer causes no repeat.
- R8: A qualified single-button press sets `mute_q` to 0 and also applies that button's step.
- R9: A cycle with `cfg_ofs_we` high loads `cfg_ofs_wdata` into `ofs_q` at the next edge.
- R10: A cycle with `cfg_mute_clr` high sets `mute_q` to 0 at the next edge.
- R11: `eff_att` equals `ofs_q + master_att` when that sum is at most 2^`ATT_W` − 1. Otherwise `eff_att` equals 2^`ATT_W` − 1.
- R12: Buttons held with no tick arriving never change `ofs_q` or `mute_q`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_ms | input | 1 | One-cycle millisecond strobe |
| vol_up_n | input | 1 | Volume-up button, low when pressed |
| vol_dn_n | input | 1 | Volume-down button, low when pressed |
| cfg_ofs_we | input | 1 | Software write strobe for the offset |
| cfg_ofs_wdata | input | OFS_W | Offset value to write |
| cfg_mute_clr | input | 1 | Software mute clear strobe |
| master_att | input | MASTER_W | Master attenuation from software |
| ofs_q | output | OFS_W | Current attenuation offset |
| mute_q | output | 1 | Mute flag |
| eff_att | output | ATT_W | Clamped sum of offset and master |

## Verification
Each button alone is held for every tick count from zero up through several repeat intervals. This separates the cutoff for a short press, the first step and each later repeat step. The same hold lengths are also run from start values at and next to both ends of the offset range, which separates correct saturation from wrap-around. Both-button holds that are short, exactly qualifying and long show that a chord toggles mute only once and never moves the offset. Single presses made while muted, together with software clears, show every path that leaves mute. A full sweep of offset against master value checks both the sum and the clamp.

// File: rtl/hvol_pkg.sv
package hvol_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_QUAL = 2'd1,
      ST_HOLD = 2'd2
   } press_st_t;
endpackage

// File: rtl/hvol_sync.sv
module hvol_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_n,
   output logic pressed
);
   logic [STAGES-1:0] chain;

   generate
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) chain[0] <= 1'b1;
               else        chain[0] <= pin_n;
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) chain[i] <= 1'b1;
               else        chain[i] <= chain[i-1];
         end
      end
   endgenerate

   assign pressed = ~chain[STAGES-1];
endmodule

// File: rtl/hvol_press_fsm.sv
module hvol_press_fsm
   import hvol_pkg::*;
#(
   parameter int QUAL_TICKS   = 50,
   parameter int REPEAT_TICKS = 200
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic up,
   input  logic dn,
   output logic step_up,
   output logic step_dn,
   output logic chord_evt
);
   localparam int QW = $clog2(QUAL_TICKS + 1);
   localparam int RW = $clog2(REPEAT_TICKS + 1);
   localparam logic [QW-1:0] Q_LAST = QW'(QUAL_TICKS - 1);
   localparam logic [RW-1:0] R_LAST = RW'(REPEAT_TICKS - 1);

   press_st_t     state;
   logic [QW-1:0] qcnt;
   logic [RW-1:0] rcnt;
   logic          seen_up, seen_dn;
   logic          dir_up, chord_lat;

   logic any_now, up_acc, dn_acc, chord_now, fire_q, fire_r;

   always_comb begin
      any_now   = up | dn;
      up_acc    = seen_up | up;
      dn_acc    = seen_dn | dn;
      chord_now = up_acc & dn_acc;
      fire_q    = (state == ST_QUAL) && tick && any_now && (qcnt == Q_LAST);
      fire_r    = (state == ST_HOLD) && tick && any_now && !chord_lat
                  && (rcnt == R_LAST);
      step_up   = (fire_q && !chord_now && up_acc) || (fire_r && dir_up);
      step_dn   = (fire_q && !chord_now && dn_acc) || (fire_r && !dir_up);
      chord_evt = fire_q && chord_now;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         qcnt      <= '0;
         rcnt      <= '0;
         seen_up   <= 1'b0;
         seen_dn   <= 1'b0;
         dir_up    <= 1'b0;
         chord_lat <= 1'b0;
      end else begin
         unique case (state)
            ST_IDLE: begin
               qcnt    <= '0;
               seen_up <= up;
               seen_dn <= dn;
               if (any_now) state <= ST_QUAL;
            end
            ST_QUAL: begin
               seen_up <= up_acc;
               seen_dn <= dn_acc;
               if (!any_now) begin
                  state <= ST_IDLE;
               end else if (tick) begin
                  if (qcnt == Q_LAST) begin
                     state     <= ST_HOLD;
                     rcnt      <= '0;
                     chord_lat <= chord_now;
                     dir_up    <= up_acc;
                  end else begin
                     qcnt <= qcnt + 1'b1;
                  end
               end
            end
            ST_HOLD: begin
               if (!any_now) begin
                  state <= ST_IDLE;
               end else if (tick && !chord_lat) begin
                  if (rcnt == R_LAST) rcnt <= '0;
                  else                rcnt <= rcnt + 1'b1;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/hvol_regs.sv
module hvol_regs #(
   parameter int OFS_W   = 5,
   parameter int OFS_RST = 27
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step_up,
   input  logic             step_dn,
   input  logic             chord_evt,
   input  logic             wr,
   input  logic [OFS_W-1:0] wdata,
   input  logic             mute_clr,
   output logic [OFS_W-1:0] ofs,
   output logic             mute
);
   localparam logic [OFS_W-1:0] OFS_MAX = '1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ofs <= OFS_W'(OFS_RST);
      end else if (wr) begin
         ofs <= wdata;
      end else if (step_up && ofs != '0) begin
         ofs <= ofs - 1'b1;
      end else if (step_dn && ofs != OFS_MAX) begin
         ofs <= ofs + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 mute <= 1'b0;
      else if (mute_clr)          mute <= 1'b0;
      else if (chord_evt)         mute <= ~mute;
      else if (step_up | step_dn) mute <= 1'b0;
   end
endmodule

// File: rtl/hvol_sum.sv
module hvol_sum #(
   parameter int OFS_W    = 5,
   parameter int MASTER_W = 6,
   parameter int ATT_W    = 6
) (
   input  logic [OFS_W-1:0]    ofs,
   input  logic [MASTER_W-1:0] master,
   output logic [ATT_W-1:0]    att
);
   localparam int SUM_W   = ((OFS_W > MASTER_W) ? OFS_W : MASTER_W) + 1;
   localparam longint SUM_MAX = (64'd1 << OFS_W) - 1 + (64'd1 << MASTER_W) - 1;
   localparam longint ATT_MAX = (64'd1 << ATT_W) - 1;

   logic [SUM_W-1:0] sum;
   assign sum = SUM_W'(ofs) + SUM_W'(master);

   generate
      if (SUM_MAX <= ATT_MAX) begin : g_direct
         assign att = ATT_W'(sum);
      end else begin : g_clamp
         localparam logic [SUM_W-1:0] LIMIT = SUM_W'(ATT_MAX);
         assign att = (sum > LIMIT) ? '1 : ATT_W'(sum);
      end
   endgenerate
endmodule

// File: rtl/hvol_ctrl.sv
module hvol_ctrl #(
   parameter int OFS_W        = 5,
   parameter int OFS_RST      = 27,
   parameter int MASTER_W     = 6,
   parameter int ATT_W        = 6,
   parameter int QUAL_TICKS   = 50,
   parameter int REPEAT_TICKS = 200,
   parameter int SYNC_STAGES  = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                tick_ms,
   input  logic                vol_up_n,
   input  logic                vol_dn_n,
   input  logic                cfg_ofs_we,
   input  logic [OFS_W-1:0]    cfg_ofs_wdata,
   input  logic                cfg_mute_clr,
   input  logic [MASTER_W-1:0] master_att,
   output logic [OFS_W-1:0]    ofs_q,
   output logic                mute_q,
   output logic [ATT_W-1:0]    eff_att
);
   generate
      if (QUAL_TICKS < 1 || REPEAT_TICKS < 1) begin : g_bad_timing
         $error("hvol_ctrl: tick counts must be at least 1");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("hvol_ctrl: synchronizer needs two or more stages");
      end
      if (OFS_RST < 0 || OFS_RST > (1 << OFS_W) - 1) begin : g_bad_rst
         $error("hvol_ctrl: reset offset out of range");
      end
      if (MASTER_W > ATT_W) begin : g_bad_master
         $error("hvol_ctrl: master wider than output field");
      end
   endgenerate

   logic up_p, dn_p;
   logic step_up, step_dn, chord_evt;

   hvol_sync #(.STAGES(SYNC_STAGES)) u_sync_up (
      .clk(clk), .rst_n(rst_n), .pin_n(vol_up_n), .pressed(up_p));
   hvol_sync #(.STAGES(SYNC_STAGES)) u_sync_dn (
      .clk(clk), .rst_n(rst_n), .pin_n(vol_dn_n), .pressed(dn_p));

   hvol_press_fsm #(.QUAL_TICKS(QUAL_TICKS), .REPEAT_TICKS(REPEAT_TICKS)) u_fsm (
      .clk(clk), .rst_n(rst_n), .tick(tick_ms), .up(up_p), .dn(dn_p),
      .step_up(step_up), .step_dn(step_dn), .chord_evt(chord_evt));

   hvol_regs #(.OFS_W(OFS_W), .OFS_RST(OFS_RST)) u_regs (
      .clk(clk), .rst_n(rst_n), .step_up(step_up), .step_dn(step_dn),
      .chord_evt(chord_evt), .wr(cfg_ofs_we), .wdata(cfg_ofs_wdata),
      .mute_clr(cfg_mute_clr), .ofs(ofs_q), .mute(mute_q));

   hvol_sum #(.OFS_W(OFS_W), .MASTER_W(MASTER_W), .ATT_W(ATT_W)) u_sum (
      .ofs(ofs_q), .master(master_att), .att(eff_att));
endmodule

// File: rtl/hvol_ctrl_chk.sv
module hvol_ctrl_chk #(
   parameter int OFS_W    = 5,
   parameter int MASTER_W = 6,
   parameter int ATT_W    = 6
) (
   input logic                clk,
   input logic                rst_n,
   input logic                tick_ms,
   input logic                cfg_ofs_we,
   input logic [OFS_W-1:0]    cfg_ofs_wdata,
   input logic                cfg_mute_clr,
   input logic [MASTER_W-1:0] master_att,
   input logic [OFS_W-1:0]    ofs_q,
   input logic                mute_q,
   input logic [ATT_W-1:0]    eff_att
);
   // Button steps move the offset by at most one per cycle (R5, R6)
   assert_single_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_ofs_we |=> (ofs_q == $past(ofs_q)) || (ofs_q == $past(ofs_q) + 1'b1)
                      || (ofs_q == $past(ofs_q) - 1'b1));

   assert_no_tick_no_change_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick_ms && !cfg_ofs_we && !cfg_mute_clr) |=> ($stable(ofs_q) && $stable(mute_q)));

   assert_mute_sets_on_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mute_q) |-> $past(tick_ms));

   assert_sw_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_mute_clr |=> !mute_q);

   assert_sw_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_ofs_we |=> (ofs_q == $past(cfg_ofs_wdata)));

   assert_sum_floor_R11: assert property (@(posedge clk) disable iff (!rst_n)
      ATT_W'(master_att) <= eff_att);
endmodule

bind hvol_ctrl hvol_ctrl_chk #(.OFS_W(OFS_W), .MASTER_W(MASTER_W), .ATT_W(ATT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .cfg_ofs_we(cfg_ofs_we),
   .cfg_ofs_wdata(cfg_ofs_wdata), .cfg_mute_clr(cfg_mute_clr),
   .master_att(master_att), .ofs_q(ofs_q), .mute_q(mute_q), .eff_att(eff_att));

// File: tb/hvol_ctrl_tb.sv
`timescale 1ns/1ps
module hvol_ctrl_tb;
   localparam int OW = 5;
   localparam int MW = 6;
   localparam int AW = 6;
   localparam int Q  = 3;
   localparam int RP = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tick_ms = 1'b0;
   logic vol_up_n = 1'b1, vol_dn_n = 1'b1;
   logic cfg_ofs_we = 1'b0;
   logic [OW-1:0] cfg_ofs_wdata = '0;
   logic cfg_mute_clr = 1'b0;
   logic [MW-1:0] master_att = '0;
   logic [OW-1:0] ofs_q;
   logic mute_q;
   logic [AW-1:0] eff_att;

   int checks = 0;
   int fails = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   hvol_ctrl #(.OFS_W(OW), .OFS_RST(27), .MASTER_W(MW), .ATT_W(AW),
               .QUAL_TICKS(Q), .REPEAT_TICKS(RP), .SYNC_STAGES(2)) u_dut (
      .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .vol_up_n(vol_up_n),
      .vol_dn_n(vol_dn_n), .cfg_ofs_we(cfg_ofs_we), .cfg_ofs_wdata(cfg_ofs_wdata),
      .cfg_mute_clr(cfg_mute_clr), .master_att(master_att), .ofs_q(ofs_q),
      .mute_q(mute_q), .eff_att(eff_att));

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic tick_pulse();
      @(negedge clk) tick_ms = 1'b1;
      @(negedge clk) tick_ms = 1'b0;
   endtask

   task automatic press(input bit up, input bit dn, input int k);
      @(negedge clk);
      vol_up_n = !up;
      vol_dn_n = !dn;
      cyc(4);
      repeat (k) tick_pulse();
      vol_up_n = 1'b1;
      vol_dn_n = 1'b1;
      cyc(4);
   endtask

   task automatic sw_write(input int v);
      @(negedge clk) begin cfg_ofs_we = 1'b1; cfg_ofs_wdata = OW'(v); end
      @(negedge clk) cfg_ofs_we = 1'b0;
   endtask

   task automatic sw_clear();
      @(negedge clk) cfg_mute_clr = 1'b1;
      @(negedge clk) cfg_mute_clr = 1'b0;
   endtask

   function automatic int n_steps(input int k);
      return (k < Q) ? 0 : 1 + (k - Q) / RP;
   endfunction

   function automatic int clamp(input int v, input int lo, input int hi);
      return (v < lo) ? lo : ((v > hi) ? hi : v);
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      int starts[6] = '{0, 1, 2, 29, 30, 31};
      cyc(3);
      rst_n = 1'b1;
      cyc(2);
      // R1 reset state
      chk("R1 ofs", ofs_q, 27);
      chk("R1 mute", mute_q, 0);

      // R2 R3 R4 R5: hold sweep for each button from mid-range
      for (int d = 0; d < 2; d++) begin
         for (int k = 0; k <= Q + 3 * RP; k++) begin
            int exp;
            sw_write(16);
            press(d == 0, d == 1, k);
            exp = (d == 0) ? 16 - n_steps(k) : 16 + n_steps(k);
            if (k < Q) chk("R2 short press", ofs_q, 16);
            else if (k < Q + RP) chk(d == 0 ? "R3 up step" : "R4 dn step", ofs_q, exp);
            else chk("R5 repeat", ofs_q, exp);
            chk("R2 mute untouched", mute_q, 0);
         end
      end

      // R6 saturation near both ends
      foreach (starts[i]) begin
         for (int m = 0; m < 3; m++) begin
            int k = Q + m * RP;
            sw_write(starts[i]);
            press(1, 0, k);
            chk("R6 sat low", ofs_q, clamp(starts[i] - n_steps(k), 0, 31));
            sw_write(starts[i]);
            press(0, 1, k);
            chk("R6 sat high", ofs_q, clamp(starts[i] + n_steps(k), 0, 31));
         end
      end

      // R7 chord toggles mute, no offset move, no repeat
      sw_write(10);
      press(1, 1, Q - 1);
      chk("R7 short chord mute", mute_q, 0);
      press(1, 1, Q);
      chk("R7 chord mute on", mute_q, 1);
      chk("R7 chord ofs", ofs_q, 10);
      press(1, 1, Q + 3 * RP);
      chk("R7 long chord mute off", mute_q, 0);
      chk("R7 long chord ofs", ofs_q, 10);

      // R8 single press leaves mute and steps
      press(1, 1, Q);
      chk("R8 setup mute", mute_q, 1);
      press(0, 1, Q);
      chk("R8 dn unmute", mute_q, 0);
      chk("R8 dn step", ofs_q, 11);
      press(1, 1, Q);
      press(1, 0, Q);
      chk("R8 up unmute", mute_q, 0);
      chk("R8 up step", ofs_q, 10);

      // R10 software clear
      press(1, 1, Q);
      chk("R10 setup mute", mute_q, 1);
      sw_clear();
      chk("R10 sw clear", mute_q, 0);

      // R9 software write and read back
      for (int v = 0; v < 32; v += 5) begin
         sw_write(v);
         chk("R9 write", ofs_q, v);
      end

      // R12 held without ticks
      sw_write(20);
      @(negedge clk) begin vol_up_n = 1'b0; vol_dn_n = 1'b0; end
      cyc(60);
      chk("R12 chord no tick mute", mute_q, 0);
      @(negedge clk) vol_dn_n = 1'b1;
      cyc(4);
      @(negedge clk) vol_up_n = 1'b1;
      cyc(4);
      @(negedge clk) vol_dn_n = 1'b0;
      cyc(60);
      chk("R12 dn no tick ofs", ofs_q, 20);
      @(negedge clk) vol_dn_n = 1'b1;
      cyc(4);

      // R11 full sum sweep
      for (int o = 0; o < 32; o++) begin
         sw_write(o);
         for (int mv = 0; mv < 64; mv++) begin
            @(negedge clk) master_att = MW'(mv);
            #1;
            chk("R11 sum", eff_att, (o + mv > 63) ? 63 : o + mv);
         end
      end

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule